// File: doc/BRIEF.md
# Processor Flags and Interrupt-Control Unit

This block owns the status word of a small 12-bit CPU with 15-bit addressing (a 3-bit field above a 12-bit offset). It also carries out the processor-control I/O instructions that read or change that word. The decoder presents a 3-bit function code with a valid strobe. In the same cycle the block answers with a skip decision, the next program counter and, for the read-flags function, a value for the accumulator together with its write enable. Any change to the status word becomes visible on the next clock edge.

Interrupts are switched on in two steps. The interrupts-on function only arms a pending-enable bit. The real enable bit turns on at the next instruction-retire pulse, so the instruction after interrupts-on always completes before an interrupt can be taken. The request bit samples the external request line every cycle. The block reports a request as taken when the enable bit is set and the inhibit bit is clear. When a taken interrupt retires, the whole status word is copied into a saved register.

Top module: `proc_flags_ctl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every bit of the status word and of the saved copy reads 0.
- R2: Function 0 with valid raises skip in the same cycle when status bit 7 (enable) is 1, and leaves skip low when it is 0.
- R3: Function 1 with valid sets status bit 12 (pending enable) at the next edge and leaves bit 7 unchanged at that edge.
- R4: A retire pulse while bit 12 is 1, with no function 2 in that cycle, sets bit 7 and clears bit 12 at the next edge. Without a retire pulse, bit 12 stays set and bit 7 does not change.
- R5: Function 2 with valid clears bits 7 and 12 at the next edge and leaves every other status bit unchanged. It takes priority over a retire-driven promotion in the same cycle.
- R6: Function 3 with valid raises skip in the same cycle when status bit 9 (request) is 1.
- R7: Status bit 9 equals the request input as it was sampled at the previous clock edge.
- R8: Function 4 with valid asserts the accumulator write enable, and the accumulator value is status bits 10:0 in bits 10:0 with the link input in bit 11. No other function asserts the write enable.
- R9: The next PC keeps bits 14:12 of the current PC. Bits 11:0 advance by 1, or by 2 when skip is high, modulo 4096.
- R10: Functions 5, 6 and 7 raise neither skip nor the write enable, and they leave the status word unchanged.
- R11: The taken output is high exactly when bit 7 is 1, bit 8 (inhibit) is 0 and bit 9 is 1.
- R12: A retire pulse while taken is high copies the current status word into the saved register at the next edge. Otherwise the saved register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fn_valid | input | 1 | Function code is valid this cycle |
| fn_code | input | 3 | Processor-control function code |
| link_in | input | 1 | Current link bit |
| irq_in | input | 1 | External interrupt request |
| retire | input | 1 | Instruction-retire pulse |
| pc_in | input | 15 | Current PC: field in 14:12, offset in 11:0 |
| flags | output | 13 | Status word |
| flags_saved | output | 13 | Saved copy of the status word |
| acc_we | output | 1 | Accumulator write enable |
| acc_val | output | 12 | Accumulator write value |
| skip | output | 1 | Skip the next instruction |
| next_pc | output | 15 | Next program counter |
| int_taken | output | 1 | Interrupt request is being taken |

## Verification
Skip, the next PC, the accumulator enable and value, and taken are combinational, so they are due in the same cycle as the function code. The status word and the saved copy are due one edge later, and the request bit lags the request input by exactly one edge. The bench drives inputs just after the falling edge and compares every output against its model in the middle of the low phase. It advances the model's state only at the rising edge, which places each same-cycle result and each next-edge result in the cycle where it is due. Corner cases covered include the promotion waiting for a later retire, interrupts-off beating a same-cycle promotion, and offset wrap with and without a skip.

// File: rtl/pflg_pkg.sv
package pflg_pkg;
   localparam int FLG_W    = 13;
   localparam int B_DF_LO  = 0;
   localparam int B_IFB_LO = 3;
   localparam int B_USER   = 6;
   localparam int B_IEN    = 7;
   localparam int B_INH    = 8;
   localparam int B_REQ    = 9;
   localparam int B_GT     = 10;
   localparam int B_LINK   = 11;
   localparam int B_DLY    = 12;
   localparam int RD_W     = 12;

   typedef logic [FLG_W-1:0] flags_t;

   typedef struct packed {
      logic skon;
      logic ion;
      logic ioff;
      logic srq;
      logic gtf;
   } fn_sel_t;
endpackage

// File: rtl/pflg_decode.sv
module pflg_decode
   import pflg_pkg::*;
#(
   parameter int FN_W = 3
) (
   input  logic            fn_valid,
   input  logic [FN_W-1:0] fn_code,
   output fn_sel_t         sel
);
   localparam int NFN = 5;

   logic [NFN-1:0] hit;

   generate
      for (genvar k = 0; k < NFN; k++) begin : g_hit
         assign hit[k] = fn_valid && (fn_code == FN_W'(k));
      end
   endgenerate

   always_comb begin
      sel.skon = hit[0];
      sel.ion  = hit[1];
      sel.ioff = hit[2];
      sel.srq  = hit[3];
      sel.gtf  = hit[4];
   end
endmodule

// File: rtl/pflg_state.sv
module pflg_state
   import pflg_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  fn_sel_t sel,
   input  logic    irq_in,
   input  logic    retire,
   output flags_t  flags_q,
   output flags_t  saved_q,
   output logic    taken
);
   logic   promote;
   flags_t flags_d;

   assign taken   = flags_q[B_IEN] & ~flags_q[B_INH] & flags_q[B_REQ];
   assign promote = retire & flags_q[B_DLY];

   always_comb begin
      flags_d         = flags_q;
      flags_d[B_REQ]  = irq_in;
      flags_d[B_LINK] = 1'b0;
      if (promote) begin
         flags_d[B_IEN] = 1'b1;
         flags_d[B_DLY] = 1'b0;
      end
      if (sel.ion) begin
         flags_d[B_DLY] = 1'b1;
      end
      if (sel.ioff) begin
         flags_d[B_IEN] = 1'b0;
         flags_d[B_DLY] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         saved_q <= '0;
      end else begin
         flags_q <= flags_d;
         if (retire && taken) begin
            saved_q <= flags_q;
         end
      end
   end
endmodule

// File: rtl/pflg_pc_step.sv
module pflg_pc_step #(
   parameter int FLD_W = 3,
   parameter int OFF_W = 12
) (
   input  logic [FLD_W+OFF_W-1:0] pc_in,
   input  logic                   skip,
   output logic [FLD_W+OFF_W-1:0] next_pc
);
   logic [OFF_W-1:0] off;
   logic [OFF_W-1:0] off_nxt;

   assign off     = pc_in[OFF_W-1:0];
   assign off_nxt = off + OFF_W'(1) + OFF_W'(skip);
   assign next_pc = {pc_in[FLD_W+OFF_W-1:OFF_W], off_nxt};
endmodule

// File: rtl/proc_flags_ctl.sv
module proc_flags_ctl
   import pflg_pkg::*;
#(
   parameter int FN_W  = 3,
   parameter int FLD_W = 3,
   parameter int OFF_W = 12,
   parameter int ACC_W = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fn_valid,
   input  logic [FN_W-1:0]        fn_code,
   input  logic                   link_in,
   input  logic                   irq_in,
   input  logic                   retire,
   input  logic [FLD_W+OFF_W-1:0] pc_in,
   output logic [FLG_W-1:0]       flags,
   output logic [FLG_W-1:0]       flags_saved,
   output logic                   acc_we,
   output logic [ACC_W-1:0]       acc_val,
   output logic                   skip,
   output logic [FLD_W+OFF_W-1:0] next_pc,
   output logic                   int_taken
);
   localparam int PC_W = FLD_W + OFF_W;

   initial begin
      if (FN_W < 3) $error("FN_W must be at least 3");
      if (ACC_W < RD_W) $error("ACC_W must hold the flags read-out");
      if (OFF_W < 2) $error("OFF_W too small");
      if (PC_W > 32) $error("PC too wide");
   end

   fn_sel_t        sel;
   flags_t         fq;
   flags_t         sq;
   logic           taken;
   logic [RD_W-1:0] rd_word;

   pflg_decode #(.FN_W(FN_W)) u_dec (
      .fn_valid (fn_valid),
      .fn_code  (fn_code),
      .sel      (sel)
   );

   pflg_state u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .irq_in  (irq_in),
      .retire  (retire),
      .flags_q (fq),
      .saved_q (sq),
      .taken   (taken)
   );

   assign skip = (sel.skon & fq[B_IEN]) | (sel.srq & fq[B_REQ]);

   pflg_pc_step #(.FLD_W(FLD_W), .OFF_W(OFF_W)) u_pc (
      .pc_in   (pc_in),
      .skip    (skip),
      .next_pc (next_pc)
   );

   assign rd_word = {link_in, fq[B_LINK-1:0]};

   generate
      if (ACC_W > RD_W) begin : g_acc_pad
         assign acc_val = {{(ACC_W-RD_W){1'b0}}, rd_word};
      end else begin : g_acc_exact
         assign acc_val = rd_word;
      end
   endgenerate

   assign acc_we      = sel.gtf;
   assign flags       = fq;
   assign flags_saved = sq;
   assign int_taken   = taken;
endmodule

// File: rtl/proc_flags_ctl_chk.sv
module proc_flags_ctl_chk #(
   parameter int FN_W  = 3,
   parameter int FLD_W = 3,
   parameter int OFF_W = 12,
   parameter int ACC_W = 12
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   fn_valid,
   input logic [FN_W-1:0]        fn_code,
   input logic                   irq_in,
   input logic                   retire,
   input logic [FLD_W+OFF_W-1:0] pc_in,
   input logic [12:0]            flags,
   input logic [12:0]            flags_saved,
   input logic                   acc_we,
   input logic                   skip,
   input logic [FLD_W+OFF_W-1:0] next_pc,
   input logic                   int_taken
);
   localparam int PC_W = FLD_W + OFF_W;

   p_ion_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_valid && fn_code == FN_W'(1)) |=> flags[12]);

   p_promote_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && flags[12] && !(fn_valid && fn_code == FN_W'(2))) |=> flags[7]);

   p_ioff_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_valid && fn_code == FN_W'(2)) |=> (!flags[7] && !flags[12]));

   p_req_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (flags[9] == $past(irq_in)));

   p_field_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      next_pc[PC_W-1:OFF_W] == pc_in[PC_W-1:OFF_W]);

   p_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_valid && fn_code >= FN_W'(5)) |-> (!skip && !acc_we));

   p_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
      int_taken |-> (flags[7] && !flags[8] && flags[9]));

   p_save_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && int_taken) |=> (flags_saved == $past(flags)));
endmodule

bind proc_flags_ctl proc_flags_ctl_chk #(
   .FN_W(FN_W), .FLD_W(FLD_W), .OFF_W(OFF_W), .ACC_W(ACC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fn_valid    (fn_valid),
   .fn_code     (fn_code),
   .irq_in      (irq_in),
   .retire      (retire),
   .pc_in       (pc_in),
   .flags       (flags),
   .flags_saved (flags_saved),
   .acc_we      (acc_we),
   .skip        (skip),
   .next_pc     (next_pc),
   .int_taken   (int_taken)
);

// File: tb/proc_flags_ctl_bench.sv
module proc_flags_ctl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fn_valid = 1'b0;
   logic [2:0]  fn_code = 3'd0;
   logic        link_in = 1'b0;
   logic        irq_in = 1'b0;
   logic        retire = 1'b0;
   logic [14:0] pc_in = 15'd0;
   logic [12:0] flags;
   logic [12:0] flags_saved;
   logic        acc_we;
   logic [11:0] acc_val;
   logic        skip;
   logic [14:0] next_pc;
   logic        int_taken;

   int n_chk = 0;
   int n_fail = 0;
   int m_flags = 0;
   int m_saved = 0;

   always #5 clk = ~clk;

   proc_flags_ctl u_proc_flags_ctl (
      .clk(clk), .rst_n(rst_n), .fn_valid(fn_valid), .fn_code(fn_code),
      .link_in(link_in), .irq_in(irq_in), .retire(retire), .pc_in(pc_in),
      .flags(flags), .flags_saved(flags_saved), .acc_we(acc_we),
      .acc_val(acc_val), .skip(skip), .next_pc(next_pc), .int_taken(int_taken)
   );

   task automatic check(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one clock: drive, compare at mid low phase, advance model at rising edge
   task automatic cyc(string tag, bit v, int code, bit lnk, bit irq, bit ret, int pc);
      bit ie, req, dly, inh, e_skip, e_we, e_taken;
      int e_pc, e_acc, nf;
      fn_valid = v; fn_code = 3'(code); link_in = lnk; irq_in = irq;
      retire = ret; pc_in = 15'(pc);
      #2;
      ie  = m_flags[7]; inh = m_flags[8]; req = m_flags[9]; dly = m_flags[12];
      e_skip  = v && ((code == 0 && ie) || (code == 3 && req));
      e_we    = v && code == 4;
      e_acc   = (m_flags & 'h7FF) | (int'(lnk) << 11);
      e_taken = ie && !inh && req;
      e_pc    = (pc & 'h7000) | ((pc + 1 + int'(e_skip)) & 'hFFF);
      check(tag, "flags", int'(flags), m_flags);
      check(tag, "saved", int'(flags_saved), m_saved);
      check(tag, "skip", int'(skip), int'(e_skip));
      check(tag, "acc_we", int'(acc_we), int'(e_we));
      if (e_we) check(tag, "acc_val", int'(acc_val), e_acc);
      check(tag, "next_pc", int'(next_pc), e_pc);
      check(tag, "taken", int'(int_taken), int'(e_taken));
      @(posedge clk);
      nf = m_flags;
      nf = req ? (nf | 'h200) : (nf & ~'h200);
      nf = irq ? (nf | 'h200) : (nf & ~'h200);
      if (ret && dly) nf = (nf | 'h80) & ~'h1000;
      if (v && code == 1) nf = nf | 'h1000;
      if (v && code == 2) nf = nf & ~'h1080;
      if (ret && e_taken) m_saved = m_flags;
      m_flags = nf;
      @(negedge clk);
   endtask

   initial begin
      #2000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      // R1: reset state, irq asserted during reset must not leak
      irq_in = 1'b1;
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      m_flags = 0; m_saved = 0;
      cyc("R1", 0, 0, 0, 0, 0, 'h0100);
      // R10: no-op functions
      cyc("R10", 1, 5, 1, 0, 1, 'h0200);
      cyc("R10", 1, 6, 0, 0, 0, 'h0300);
      cyc("R10", 1, 7, 1, 0, 1, 'h0400);
      // R2: no skip while enable is off
      cyc("R2", 1, 0, 0, 0, 0, 'h1005);
      // R6/R7: request bit follows input with one edge lag
      cyc("R6", 1, 3, 0, 1, 0, 'h2010);
      cyc("R7", 1, 3, 0, 0, 0, 'h2011);
      cyc("R7", 1, 3, 0, 0, 0, 'h2012);
      // R3: arm, no immediate enable
      cyc("R3", 1, 1, 0, 0, 1, 'h0020);
      cyc("R4", 0, 0, 0, 0, 0, 'h0021);
      cyc("R4", 1, 0, 0, 0, 0, 'h0022);
      // R4: promotion on retire
      cyc("R4", 0, 0, 0, 0, 1, 'h0023);
      // R2: skip now that enable is on
      cyc("R2", 1, 0, 0, 0, 0, 'h0024);
      // R9: wrap with and without skip
      cyc("R9", 1, 0, 0, 0, 0, 'h7FFE);
      cyc("R9", 0, 0, 0, 0, 0, 'h5FFF);
      cyc("R9", 1, 0, 0, 0, 0, 'h3FFF);
      // R8: read flags with link high and low
      cyc("R8", 1, 4, 1, 1, 0, 'h0040);
      cyc("R8", 1, 4, 0, 1, 0, 'h0041);
      // R11/R12: taken and saved copy
      cyc("R11", 0, 0, 0, 1, 0, 'h0050);
      cyc("R12", 0, 0, 0, 1, 1, 'h0051);
      cyc("R12", 0, 0, 0, 0, 1, 'h0052);
      cyc("R11", 0, 0, 0, 0, 0, 'h0053);
      // R5: interrupts off clears enable only
      cyc("R5", 1, 2, 0, 1, 0, 'h0060);
      cyc("R5", 1, 4, 0, 1, 0, 'h0061);
      // R5: off beats a same-cycle promotion
      cyc("R5", 1, 1, 0, 0, 0, 'h0070);
      cyc("R5", 1, 2, 0, 0, 1, 'h0071);
      cyc("R5", 1, 0, 0, 0, 1, 'h0072);
      // R10: no-op keeps armed bit
      cyc("R10", 1, 1, 0, 0, 0, 'h0080);
      cyc("R10", 1, 6, 0, 1, 0, 'h0081);
      cyc("R4", 0, 0, 0, 1, 1, 'h0082);
      cyc("R11", 1, 3, 0, 0, 0, 'h0083);
      cyc("R1", 0, 0, 0, 0, 0, 'h0084);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule